// File: doc/BRIEF.md
# Asynchronous Serial Channel with Byte Register Map

This block is one asynchronous serial channel behind a byte-wide register window. Software writes a mode byte to pick the character format: 7 or 8 data bits, one of four parity treatments, and 1 or 2 stop bits. It then writes bytes into a transmit holding register and reads received bytes from a receive holding register. Receive errors gather in a sticky status byte that clears when it is read. A second status byte reports separately whether the holding register is occupied and whether the shifter is busy.

Bit timing comes from an external rate generator. That generator pulses `brg_tick` once per half bit time and takes its prescaler and divisor settings from two registers inside this channel. Three single-cycle interrupt outputs report these events: a character has been fully sent, a character has arrived, and a character has arrived with errors. A mode bit decides whether an erroneous character is reported on the arrival line or on the separate error line.

After every write to the mode register, both directions stay blocked for a short settling window counted in rate ticks. Software can therefore rewrite the format without stray traffic.

Top module: `uart_chan`

## Requirements
- R1: After reset, `txd` is high, all three interrupts are low, and the mode, error, status, prescaler and divisor registers read zero.
- R2: Registers are decoded at byte offsets mode 0x0, receive 0x2, error 0x3, transmit 0x4, transmit status 0x5, prescaler 0x6 and divisor 0x7. Mode, prescaler and divisor read back what was written, and the prescaler and divisor values drive `brg_sel` and `brg_div`.
- R3: A transmitted frame is a low start bit, then the data bits least significant first (8 when mode bit 2 is set, otherwise the low 7), then the parity bit if any, then high stop bits. Each bit lasts two `brg_tick` periods.
- R4: Mode bits 4:3 select parity: 00 none, 01 a parity bit that is always 0, 10 odd, 11 even. Odd and even are computed over the data bits actually sent.
- R5: Mode bit 1 selects two stop bits instead of one, which lengthens the frame by one bit time.
- R6: Transmit status bit 1 is set while the transmit register holds a byte that the shifter has not yet taken. Bit 0 is set while the shifter is sending.
- R7: `irq_tx` pulses for one cycle at the end of the last stop bit of each transmitted character.
- R8: The receiver finds the start bit on a tick, samples each later bit two ticks apart, stores the character in the receive register and reports it. In 7-bit mode, bit 7 of the received byte reads 0.
- R9: Error bit 2 records a parity mismatch in odd or even mode. In the always-0 parity mode, no parity error is ever flagged, whatever parity bit arrives.
- R10: Error bit 1 records a framing error when the first stop bit samples low.
- R11: Error bit 0 records an overrun when a character completes before the previous one was read. The new byte replaces the old one, and reading offset 0x3 clears all error bits.
- R12: With mode bit 0 set, every received character pulses `irq_rx`. With it clear, a character with any error pulses only `irq_err`, and an error-free one pulses only `irq_rx`.
- R13: Transmit runs only while mode bits 7 and 6 are set, and receive only while bits 7 and 5 are set. After any mode write, both stay off for two ticks before they take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 4 | Register byte offset within the channel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| brg_tick | input | 1 | One-cycle pulse per half bit time |
| brg_sel | output | 8 | Prescaler select for the rate generator |
| brg_div | output | 8 | Divisor count for the rate generator |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq_tx | output | 1 | Character fully sent |
| irq_rx | output | 1 | Character received |
| irq_err | output | 1 | Character received with errors (when routed) |

## Verification
The transmitter is driven with four formats that differ in data length, parity kind and stop count. Its line is sampled at every bit centre, so a wrong bit order, wrong parity sense or missing stop bit each show as a distinct mismatch, and the timing of `irq_tx` confirms the frame length. The receiver is fed frames that are correct, frames with a flipped parity bit, and frames with a low stop bit. This separates parity checking from framing, shows that the always-0 mode ignores the parity bit, and shows how the routing bit moves an error between the two interrupt lines. Two back-to-back frames with no read between them exercise overrun and the clear on read. A mode write onto a byte that is already queued tells the settling window apart from an immediate start.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    localparam int DATA_W = 8;
    localparam int REG_AW = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_e;

    localparam logic [REG_AW-1:0] OFS_MODE  = 4'h0;
    localparam logic [REG_AW-1:0] OFS_RBUF  = 4'h2;
    localparam logic [REG_AW-1:0] OFS_ERR   = 4'h3;
    localparam logic [REG_AW-1:0] OFS_TBUF  = 4'h4;
    localparam logic [REG_AW-1:0] OFS_TSTAT = 4'h5;
    localparam logic [REG_AW-1:0] OFS_PSEL  = 4'h6;
    localparam logic [REG_AW-1:0] OFS_DIV   = 4'h7;

    // Parity bit for the data bits actually framed
    function automatic logic parity_of(input par_e p, input logic [DATA_W-1:0] d,
                                       input logic eight);
        logic x;
        x = eight ? ^d : ^d[DATA_W-2:0];
        case (p)
            PAR_ODD:  return ~x;
            PAR_EVEN: return x;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_chan_tx.sv
module uart_chan_tx
    import uart_chan_pkg::*;
#(
    parameter int FRAME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    input  logic              eight,
    input  logic              two_stop,
    input  par_e              par,
    output logic              take,
    output logic              busy,
    output logic              done,
    output logic              txd
);

    localparam int CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic               half;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               done;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits, len;

    always_comb begin
        nbits = eight ? CNT_W'(8) : CNT_W'(7);
        len   = CNT_W'(1) + nbits + CNT_W'(par != PAR_NONE)
              + (two_stop ? CNT_W'(2) : CNT_W'(1));
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) frame[i+1] = data[i];
        end
        if (par != PAR_NONE) frame[nbits + CNT_W'(1)] = parity_of(par, data, eight);

        st_d      = st_q;
        st_d.done = 1'b0;
        take      = 1'b0;
        if (tick) begin
            if (!st_q.busy) begin
                if (req && en) begin
                    st_d.busy = 1'b1;
                    st_d.half = 1'b0;
                    st_d.sh   = frame;
                    st_d.cnt  = len;
                    take      = 1'b1;
                end
            end else if (!st_q.half) begin
                st_d.half = 1'b1;
            end else begin
                st_d.half = 1'b0;
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign txd  = st_q.busy ? st_q.sh[0] : 1'b1;

endmodule

// File: rtl/uart_chan_rx.sv
module uart_chan_rx
    import uart_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              rxd,
    input  logic              eight,
    input  par_e              par,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);

    localparam int IDX_W = $clog2(DATA_W + 3);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   active;
        logic                   half;
        logic [IDX_W-1:0]       idx;
        logic [DATA_W-1:0]      data;
        logic                   par_s;
        logic                   done;
        logic                   perr;
        logic                   ferr;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic             line;
    logic [IDX_W-1:0] nbits;
    logic             has_par;
    logic             checked;

    always_comb begin
        line    = st_q.sync[SYNC_STAGES-1];
        nbits   = eight ? IDX_W'(8) : IDX_W'(7);
        has_par = (par != PAR_NONE);
        checked = (par == PAR_ODD) || (par == PAR_EVEN);

        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rxd};
        st_d.done = 1'b0;
        if (!en) begin
            st_d.active = 1'b0;
        end else if (tick) begin
            if (!st_q.active) begin
                if (!line) begin
                    st_d.active = 1'b1;
                    st_d.half   = 1'b0;
                    st_d.idx    = '0;
                    st_d.data   = '0;
                end
            end else if (!st_q.half) begin
                st_d.half = 1'b1;
            end else begin
                st_d.half = 1'b0;
                st_d.idx  = st_q.idx + IDX_W'(1);
                if (st_q.idx < nbits) begin
                    st_d.data[st_q.idx[2:0]] = line;
                end else if (has_par && st_q.idx == nbits) begin
                    st_d.par_s = line;
                end else begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.ferr   = !line;
                    st_d.perr   = checked
                                && (st_q.par_s != parity_of(par, st_q.data, eight));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign data = st_q.data;
    assign perr = st_q.perr;
    assign ferr = st_q.ferr;

endmodule

// File: rtl/uart_chan.sv
module uart_chan
    import uart_chan_pkg::*;
#(
    parameter int GUARD_TICKS = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              brg_tick,
    output logic [DATA_W-1:0] brg_sel,
    output logic [DATA_W-1:0] brg_div,
    output logic              txd,
    input  logic              rxd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);

    localparam int GUARD_W = $clog2(GUARD_TICKS + 1);

    typedef struct packed {
        logic [DATA_W-1:0]  mode;
        logic [DATA_W-1:0]  rbuf;
        logic               rfull;
        logic [2:0]         err;
        logic [DATA_W-1:0]  tbuf;
        logic               tbf;
        logic [DATA_W-1:0]  psel;
        logic [DATA_W-1:0]  div;
        logic [GUARD_W-1:0] guard;
        logic               irq_rx;
        logic               irq_err;
    } regs_t;

    regs_t st_d, st_q;

    logic              tx_en, rx_en, tx_take, tx_busy, tx_done;
    logic              rx_done, rx_perr, rx_ferr, rbuf_rd, ovr, bad;
    logic [DATA_W-1:0] rx_data;
    par_e              par;

    assign par   = par_e'(st_q.mode[4:3]);
    assign tx_en = st_q.mode[7] && st_q.mode[6] && (st_q.guard == '0);
    assign rx_en = st_q.mode[7] && st_q.mode[5] && (st_q.guard == '0);

    uart_chan_tx #(.FRAME_W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (brg_tick),
        .en       (tx_en),
        .req      (st_q.tbf),
        .data     (st_q.tbuf),
        .eight    (st_q.mode[2]),
        .two_stop (st_q.mode[1]),
        .par      (par),
        .take     (tx_take),
        .busy     (tx_busy),
        .done     (tx_done),
        .txd      (txd)
    );

    uart_chan_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (brg_tick),
        .en    (rx_en),
        .rxd   (rxd),
        .eight (st_q.mode[2]),
        .par   (par),
        .done  (rx_done),
        .data  (rx_data),
        .perr  (rx_perr),
        .ferr  (rx_ferr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq_rx  = 1'b0;
        st_d.irq_err = 1'b0;
        rbuf_rd      = rd_en && (addr == OFS_RBUF);
        ovr          = st_q.rfull && !rbuf_rd;
        bad          = rx_perr || rx_ferr || ovr;

        if (brg_tick && st_q.guard != '0) st_d.guard = st_q.guard - GUARD_W'(1);
        if (tx_take)                      st_d.tbf   = 1'b0;
        if (rbuf_rd)                      st_d.rfull = 1'b0;
        if (rd_en && addr == OFS_ERR)     st_d.err   = '0;

        if (wr_en) begin
            case (addr)
                OFS_MODE: begin
                    st_d.mode  = wdata;
                    st_d.guard = GUARD_W'(GUARD_TICKS);
                end
                OFS_TBUF: begin
                    st_d.tbuf = wdata;
                    st_d.tbf  = 1'b1;
                end
                OFS_PSEL: st_d.psel = wdata;
                OFS_DIV:  st_d.div  = wdata;
                default: ;
            endcase
        end

        if (rx_done) begin
            st_d.rbuf  = rx_data;
            st_d.rfull = 1'b1;
            st_d.err   = st_d.err | {rx_perr, rx_ferr, ovr};
            if (bad && !st_q.mode[0]) st_d.irq_err = 1'b1;
            else                      st_d.irq_rx  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            OFS_MODE:  rdata = st_q.mode;
            OFS_RBUF:  rdata = st_q.rbuf;
            OFS_ERR:   rdata = {5'b0, st_q.err};
            OFS_TBUF:  rdata = st_q.tbuf;
            OFS_TSTAT: rdata = {6'b0, st_q.tbf, tx_busy};
            OFS_PSEL:  rdata = st_q.psel;
            OFS_DIV:   rdata = st_q.div;
            default:   rdata = '0;
        endcase
    end

    assign brg_sel = st_q.psel;
    assign brg_div = st_q.div;
    assign irq_tx  = tx_done;
    assign irq_rx  = st_q.irq_rx;
    assign irq_err = st_q.irq_err;

endmodule

// File: rtl/uart_chan_chk.sv
module uart_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_tx,
    input logic irq_rx,
    input logic irq_err,
    input logic tx_busy,
    input logic tbf,
    input logic rfull,
    input logic err_ovr,
    input logic isrm,
    input logic tx_ok
);

    // R7
    tx_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> ($past(tx_busy) && !tx_busy));

    // R6
    load_from_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tbf));

    // R13
    settled_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_ok));

    // R12
    err_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (!$past(isrm) && !irq_rx));

    // R11
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(rfull));

endmodule

bind uart_chan uart_chan_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .irq_err (irq_err),
    .tx_busy (tx_busy),
    .tbf     (st_q.tbf),
    .rfull   (st_q.rfull),
    .err_ovr (st_q.err[0]),
    .isrm    (st_q.mode[0]),
    .tx_ok   (tx_en)
);

// File: tb/uart_chan_tb.sv
module uart_chan_tb;
    import uart_chan_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, brg_sel, brg_div;
    logic       brg_tick;
    logic       txd, rxd = 1'b1;
    logic       irq_tx, irq_rx, irq_err;

    int checks = 0, fails = 0;
    int n_tx = 0, n_rx = 0, n_er = 0;

    always #2 clk = ~clk;

    uart_chan u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .brg_tick(brg_tick), .brg_sel(brg_sel),
        .brg_div(brg_div), .txd(txd), .rxd(rxd), .irq_tx(irq_tx),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // {mode, data, expected rbuf, flip parity, stop level, expect irq_err, 2'b0, expected error bits}
    localparam logic [31:0] RXV [0:5] = '{
        32'hE53C3C40,   // R8 8N1, clean
        32'hF40F0F40,   // R4 8 odd, clean
        32'hF40F0FE4,   // R9 R12 8 odd, bad parity, routed to error line
        32'hE8FF7FC0,   // R9 7 bits, always-0 parity, wrong bit ignored
        32'hFD010102,   // R10 R12 8 even, low stop, routed to receive line
        32'hF8C34340    // R8 7 even, bit 7 reads 0
    };

    initial begin
        brg_tick = 1'b0;
        forever begin
            repeat (7) @(negedge clk);
            brg_tick = 1'b1;
            @(negedge clk);
            brg_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_tx)  n_tx++;
            if (irq_rx)  n_rx++;
            if (irq_err) n_er++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic par_for(input logic [7:0] m, input logic [7:0] dat);
        logic x;
        x = m[2] ? ^dat : ^dat[6:0];
        case (m[4:3])
            2'b10:   return ~x;
            2'b11:   return x;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int build_frame(input logic [7:0] m, input logic [7:0] dat,
                                       output logic [11:0] f);
        int n;
        int nd;
        nd = m[2] ? 8 : 7;
        f = '1;
        f[0] = 1'b0;
        n = 1;
        for (int i = 0; i < nd; i++) begin
            f[n] = dat[i];
            n++;
        end
        if (m[4:3] != 2'b00) begin
            f[n] = par_for(m, dat);
            n++;
        end
        n += m[1] ? 2 : 1;
        return n;
    endfunction

    task automatic tx_frame(input logic [7:0] m, input logic [7:0] dat);
        logic [11:0] f;
        int len;
        int k;
        logic [7:0] v;
        len = build_frame(m, dat, f);
        bus_write(OFS_MODE, m);
        repeat (40) @(negedge clk);
        bus_write(OFS_TBUF, dat);
        k = 0;
        while (txd && k < 200) begin
            @(negedge clk);
            k++;
        end
        check("R3 start bit seen", 32'(txd), 32'd0);
        for (int i = 0; i < len; i++) begin
            repeat (8) @(negedge clk);
            if (i == 0) begin
                addr = OFS_TSTAT;
                #1 check("R6 status while sending", 32'(rdata[1:0]), 32'd1);
            end
            check($sformatf("R3 R4 R5 bit %0d of mode %h", i, m), 32'(txd), 32'(f[i]));
            repeat (8) @(negedge clk);
        end
        check("R7 R5 irq_tx at frame end", 32'(irq_tx), 32'd1);
        bus_read(OFS_TSTAT, v);
        check("R6 status idle", 32'(v), 32'd0);
    endtask

    task automatic rx_send(input logic [7:0] m, input logic [7:0] dat,
                           input logic flip, input logic stop);
        int nd;
        nd = m[2] ? 8 : 7;
        @(posedge brg_tick);
        @(negedge clk);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rxd = dat[i];
            repeat (16) @(negedge clk);
        end
        if (m[4:3] != 2'b00) begin
            rxd = par_for(m, dat) ^ flip;
            repeat (16) @(negedge clk);
        end
        rxd = stop;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [31:0] e;
        int rx0, er0, tx0, lows;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 txd idle", 32'(txd), 32'd1);
        check("R1 irqs low", 32'({irq_tx, irq_rx, irq_err}), 32'd0);
        bus_read(OFS_MODE, v);  check("R1 mode", 32'(v), 32'd0);
        bus_read(OFS_ERR, v);   check("R1 error", 32'(v), 32'd0);
        bus_read(OFS_TSTAT, v); check("R1 tx status", 32'(v), 32'd0);
        check("R1 rate outputs", 32'({brg_sel, brg_div}), 32'd0);

        // R2 register map
        bus_write(OFS_PSEL, 8'h0B);
        bus_write(OFS_DIV, 8'h40);
        bus_read(OFS_PSEL, v); check("R2 prescaler readback", 32'(v), 32'h0B);
        bus_read(OFS_DIV, v);  check("R2 divisor readback", 32'(v), 32'h40);
        check("R2 rate outputs", 32'({brg_sel, brg_div}), 32'h0B40);
        bus_write(OFS_MODE, 8'hE4);
        bus_read(OFS_MODE, v); check("R2 mode readback", 32'(v), 32'hE4);

        // Transmit formats (R3 R4 R5 R6 R7)
        tx_frame(8'hE4, 8'hA5);
        tx_frame(8'hEE, 8'h3C);
        tx_frame(8'hF0, 8'h55);
        tx_frame(8'hFC, 8'h81);

        // Receive table (R8 R9 R10 R12)
        for (int t = 0; t < 6; t++) begin
            e = RXV[t];
            bus_write(OFS_MODE, e[31:24]);
            repeat (40) @(negedge clk);
            rx0 = n_rx;
            er0 = n_er;
            rx_send(e[31:24], e[23:16], e[7], e[6]);
            bus_read(OFS_RBUF, v);
            check($sformatf("R8 rbuf entry %0d", t), 32'(v), 32'(e[15:8]));
            bus_read(OFS_ERR, v);
            check($sformatf("R9 R10 errors entry %0d", t), 32'(v), 32'(e[2:0]));
            check($sformatf("R12 irq_err count entry %0d", t), n_er - er0, 32'(e[5]));
            check($sformatf("R12 irq_rx count entry %0d", t), n_rx - rx0, 32'(!e[5]));
        end

        // R11 overrun and clear on read
        bus_write(OFS_MODE, 8'hE4);
        repeat (40) @(negedge clk);
        rx0 = n_rx;
        er0 = n_er;
        rx_send(8'hE4, 8'h11, 1'b0, 1'b1);
        rx_send(8'hE4, 8'h22, 1'b0, 1'b1);
        bus_read(OFS_ERR, v);  check("R11 overrun flag", 32'(v), 32'd1);
        bus_read(OFS_ERR, v);  check("R11 cleared by read", 32'(v), 32'd0);
        bus_read(OFS_RBUF, v); check("R11 newest byte kept", 32'(v), 32'h22);
        check("R11 R12 overrun on irq_err", n_er - er0, 32'd1);
        check("R11 R12 first byte on irq_rx", n_rx - rx0, 32'd1);

        // R13 transmit gating and settling window
        bus_write(OFS_MODE, 8'h84);
        repeat (40) @(negedge clk);
        tx0 = n_tx;
        bus_write(OFS_TBUF, 8'h5A);
        lows = 0;
        repeat (60) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R13 no send while disabled", lows, 32'd0);
        bus_read(OFS_TSTAT, v);
        check("R13 R6 byte held", 32'(v), 32'd2);
        bus_write(OFS_MODE, 8'hC4);
        lows = 0;
        repeat (16) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R13 quiet during settling", lows, 32'd0);
        lows = 0;
        repeat (40) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R13 starts after settling", 32'(lows > 0), 32'd1);
        repeat (200) @(negedge clk);
        check("R13 R7 frame completed", n_tx - tx0, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule